// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the register stack of a floating-point unit: eight 80-bit registers, a 3-bit top-of-stack pointer, and one tag bit for each register that marks it full or empty. Requests name registers relative to the top pointer. ST(i) is physical register (TOP + i) mod 8, and the pointer wraps around in both directions. One request is accepted per clock. A request can push a value, pop the top value, read ST(i), write ST(i), or write ST(i) and then pop.

The controller finds stack faults before anything is committed. Reading an empty register as a source is an underflow. Pushing into a register that is still full is an overflow. On either fault the registers, the tags and the pointer stay as they were, and a stack-fault pulse is raised for one cycle. The C1 condition flag shows which fault it was: 1 for overflow and 0 for underflow. Every stack operation that succeeds clears C1.

The register array has one write port and one registered read port, so it can map onto block RAM. All outputs are registered. A request issued before a rising edge is visible on the outputs right after that edge.

Top module: `fstk_ctrl`

## Requirements
- R1: A pop (op_code 2) with ST(0) full returns the ST(0) value on rd_data with rd_valid high, clears the tag of ST(0), and increments top_ptr by 1 modulo 8.
- R2: A push (op_code 1) into an empty register decrements top_ptr by 1 modulo 8, stores wr_data in the new ST(0), and sets its tag.
- R3: A pop, a read (op_code 3) of an empty ST(i), or a write-and-pop (op_code 5) with ST(0) empty is an underflow. It pulses stack_fault for one cycle, drives c1_flag to 0, and leaves rd_valid low.
- R4: A push whose target register (TOP-1) is full is an overflow. It pulses stack_fault for one cycle and drives c1_flag to 1.
- R5: A faulting request changes no register contents, no tag, top_ptr or rd_data.
- R6: ST(i) addresses physical register (top_ptr + op_idx) mod 8, and bit p of tag_full belongs to physical register p.
- R7: After reset, top_ptr is 0, all tags are empty, and stack_fault, c1_flag and rd_valid are 0.
- R8: A write (op_code 4) stores wr_data in ST(i) and sets its tag. It never faults and leaves top_ptr unchanged.
- R9: A write-and-pop stores wr_data in ST(i) first and then pops. With op_idx 1 the value becomes the new ST(0). With op_idx 0 the written register ends up empty.
- R10: Every stack operation that succeeds drives c1_flag to 0. Idle cycles (op_valid low), op_code 0, and the unused codes 6 and 7 change no state, and c1_flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request valid this cycle |
| op_code | input | 3 | 0 none, 1 push, 2 pop, 3 read, 4 write, 5 write-and-pop |
| op_idx | input | PTR_W (3) | Relative register index i of ST(i) |
| wr_data | input | DATA_W (80) | Value for push and write |
| rd_data | output | DATA_W (80) | Value returned by read or pop |
| rd_valid | output | 1 | rd_data was updated by the previous request |
| stack_fault | output | 1 | One-cycle stack fault pulse |
| c1_flag | output | 1 | Condition flag C1 |
| top_ptr | output | PTR_W (3) | Current top-of-stack pointer |
| tag_full | output | DEPTH (8) | Per-physical-register full bits |

## Verification
The bench builds the block with its default values: 80-bit data and eight registers. With eight registers, eight pushes fill the stack, so the ninth push overflows. The fill also walks the pointer from 0 down through 7 and around again. Relative indices that wrap past physical register 7 are therefore reached with only a few pushes, and the tag vector can be compared bit by bit against the physical positions.

// File: rtl/fstk_pkg.sv
package fstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_READ  = 3'd3,
    OP_WRITE = 3'd4,
    OP_WPOP  = 3'd5
  } fstk_op_e;
endpackage

// File: rtl/fstk_ptr.sv
module fstk_ptr #(
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_dn,
  input  logic             step_up,
  input  logic [PTR_W-1:0] rel_idx,
  output logic [PTR_W-1:0] top_q,
  output logic [PTR_W-1:0] top_dn,
  output logic [PTR_W-1:0] rel_addr
);
  // pointer arithmetic wraps naturally at PTR_W bits
  assign top_dn   = top_q - PTR_W'(1);
  assign rel_addr = top_q + rel_idx;

  always_ff @(posedge clk) begin
    if (rst)          top_q <= '0;
    else if (step_dn) top_q <= top_dn;
    else if (step_up) top_q <= top_q + PTR_W'(1);
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    !(step_dn && step_up)); // R1

  AST_PTR_RESET: assert property (@(posedge clk)
    rst |=> (top_q == '0)); // R7
endmodule

// File: rtl/fstk_tags.sv
module fstk_tags #(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_addr,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_addr,
  output logic [DEPTH-1:0] tags_q
);
  // clear wins over set: a write-then-pop onto ST(0) leaves it empty
  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (rst)                                        tags_q[g] <= 1'b0;
      else if (clr_en && (clr_addr == PTR_W'(g)))     tags_q[g] <= 1'b0;
      else if (set_en && (set_addr == PTR_W'(g)))     tags_q[g] <= 1'b1;
    end
  end

  AST_TAGS_RESET: assert property (@(posedge clk)
    rst |=> (tags_q == '0)); // R7

  AST_CLR_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (clr_en && set_en && (clr_addr == set_addr)) |=> !tags_q[$past(clr_addr)]); // R9
endmodule

// File: rtl/fstk_regfile.sv
module fstk_regfile #(
  parameter int DATA_W = 80,
  parameter int DEPTH  = 8,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] mem [DEPTH];

  // one write port, one registered read port, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q    <= mem[raddr];
  end
endmodule

// File: rtl/fstk_decode.sv
module fstk_decode
  import fstk_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PTR_W = 3
) (
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [PTR_W-1:0] top_q,
  input  logic [PTR_W-1:0] top_dn,
  input  logic [PTR_W-1:0] rel_addr,
  input  logic [DEPTH-1:0] tags_q,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic             re,
  output logic [PTR_W-1:0] raddr,
  output logic             set_en,
  output logic             clr_en,
  output logic [PTR_W-1:0] clr_addr,
  output logic             step_dn,
  output logic             step_up,
  output logic             fault_now,
  output logic             c1_upd,
  output logic             c1_val
);
  fstk_op_e op_e;
  logic     top_full, dn_full, rel_full;

  assign op_e     = fstk_op_e'(op_code);
  assign top_full = tags_q[top_q];
  assign dn_full  = tags_q[top_dn];
  assign rel_full = tags_q[rel_addr];
  assign clr_addr = top_q;

  always_comb begin
    we        = 1'b0;
    waddr     = rel_addr;
    re        = 1'b0;
    raddr     = rel_addr;
    set_en    = 1'b0;
    clr_en    = 1'b0;
    step_dn   = 1'b0;
    step_up   = 1'b0;
    fault_now = 1'b0;
    c1_upd    = 1'b0;
    c1_val    = 1'b0;
    if (op_valid) begin
      case (op_e)
        OP_PUSH: begin
          c1_upd = 1'b1;
          waddr  = top_dn;
          if (dn_full) begin
            fault_now = 1'b1;
            c1_val    = 1'b1;
          end else begin
            we      = 1'b1;
            set_en  = 1'b1;
            step_dn = 1'b1;
          end
        end
        OP_POP: begin
          c1_upd = 1'b1;
          raddr  = top_q;
          if (!top_full) fault_now = 1'b1;
          else begin
            re      = 1'b1;
            clr_en  = 1'b1;
            step_up = 1'b1;
          end
        end
        OP_READ: begin
          c1_upd = 1'b1;
          if (!rel_full) fault_now = 1'b1;
          else           re        = 1'b1;
        end
        OP_WRITE: begin
          c1_upd = 1'b1;
          we     = 1'b1;
          set_en = 1'b1;
        end
        OP_WPOP: begin
          c1_upd = 1'b1;
          if (!top_full) fault_now = 1'b1;
          else begin
            we      = 1'b1;
            set_en  = 1'b1;
            clr_en  = 1'b1;
            step_up = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // a fault never lets a write or a pointer step through
  always_comb begin
    AST_FAULT_BLOCKS_COMMIT: assert (!(fault_now && (we || step_dn || step_up || clr_en))); // R5
  end
endmodule

// File: rtl/fstk_ctrl.sv
module fstk_ctrl #(
  parameter  int DATA_W = 80,
  parameter  int DEPTH  = 8,
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [2:0]        op_code,
  input  logic [PTR_W-1:0]  op_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              stack_fault,
  output logic              c1_flag,
  output logic [PTR_W-1:0]  top_ptr,
  output logic [DEPTH-1:0]  tag_full
);
  logic             we, re, set_en, clr_en, step_dn, step_up;
  logic             fault_now, c1_upd, c1_val;
  logic [PTR_W-1:0] waddr, raddr, clr_addr, top_q, top_dn, rel_addr;
  logic [DEPTH-1:0] tags_q;
  logic             fault_q, c1_q, rd_valid_q;

  fstk_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .step_dn(step_dn), .step_up(step_up),
    .rel_idx(op_idx), .top_q(top_q), .top_dn(top_dn), .rel_addr(rel_addr)
  );

  fstk_tags #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_tags (
    .clk(clk), .rst(rst), .set_en(set_en), .set_addr(waddr),
    .clr_en(clr_en), .clr_addr(clr_addr), .tags_q(tags_q)
  );

  fstk_decode #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_dec (
    .op_valid(op_valid), .op_code(op_code), .top_q(top_q), .top_dn(top_dn),
    .rel_addr(rel_addr), .tags_q(tags_q), .we(we), .waddr(waddr), .re(re),
    .raddr(raddr), .set_en(set_en), .clr_en(clr_en), .clr_addr(clr_addr),
    .step_dn(step_dn), .step_up(step_up), .fault_now(fault_now),
    .c1_upd(c1_upd), .c1_val(c1_val)
  );

  fstk_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_rf (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .re(re), .raddr(raddr), .rdata_q(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q    <= 1'b0;
      c1_q       <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      fault_q    <= fault_now;
      rd_valid_q <= re;
      if (c1_upd) c1_q <= c1_val;
    end
  end

  assign stack_fault = fault_q;
  assign c1_flag     = c1_q;
  assign rd_valid    = rd_valid_q;
  assign top_ptr     = top_q;
  assign tag_full    = tags_q;

  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(op_valid && op_code == 3'd2) && !fault_q)
      |-> (top_q == PTR_W'($past(top_q) + PTR_W'(1))) && rd_valid_q); // R1

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(op_valid && op_code == 3'd1) && !fault_q)
      |-> (top_q == PTR_W'($past(top_q) - PTR_W'(1))) && tags_q[top_q]); // R2

  AST_UNDERFLOW_C1: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !$past(op_code == 3'd1)) |-> (!c1_q && !rd_valid_q)); // R3

  AST_OVERFLOW_C1: assert property (@(posedge clk) disable iff (rst)
    (fault_q && c1_q) |-> $past(op_valid && op_code == 3'd1)); // R4

  AST_FAULT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> ($stable(top_q) && $stable(tags_q))); // R5

  AST_WRITE_KEEPS_TOP: assert property (@(posedge clk) disable iff (rst)
    $past(op_valid && op_code == 3'd4) |-> (!fault_q && $stable(top_q))); // R8

  AST_C1_CLEAN: assert property (@(posedge clk) disable iff (rst)
    ($past(op_valid && op_code != 3'd0 && op_code <= 3'd5) && !fault_q) |-> !c1_q); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $past(!op_valid) |-> ($stable(top_q) && $stable(tags_q) && $stable(c1_q) && !fault_q)); // R10
endmodule

// File: tb/test_fstk_ctrl.sv
module test_fstk_ctrl;
  localparam int CLK_P = 10;
  localparam int DW    = 80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [2:0]    op_idx = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, stack_fault, c1_flag;
  logic [2:0]    top_ptr;
  logic [7:0]    tag_full;

  int n_chk = 0;
  int n_fail = 0;

  // bench-side expectation of the architectural stack state
  logic [2:0]    m_top;
  logic [7:0]    m_tag;
  logic [DW-1:0] m_reg [8];
  logic          m_c1;

  always #(CLK_P/2) clk = ~clk;

  fstk_ctrl i_fstk_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_idx(op_idx), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .stack_fault(stack_fault), .c1_flag(c1_flag),
    .top_ptr(top_ptr), .tag_full(tag_full)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic v, input logic [2:0] op, input logic [2:0] idx,
                       input logic [DW-1:0] d, input string req);
    logic          e_fault = 1'b0;
    logic          e_rv    = 1'b0;
    logic [DW-1:0] e_rd    = '0;
    logic [2:0]    p       = m_top + idx;
    logic [2:0]    nt      = m_top - 3'd1;
    if (v) begin
      case (op)
        3'd1: if (m_tag[nt]) begin e_fault = 1; m_c1 = 1; end
              else begin m_top = nt; m_reg[nt] = d; m_tag[nt] = 1; m_c1 = 0; end
        3'd2: if (!m_tag[m_top]) begin e_fault = 1; m_c1 = 0; end
              else begin e_rv = 1; e_rd = m_reg[m_top]; m_tag[m_top] = 0;
                         m_top = m_top + 3'd1; m_c1 = 0; end
        3'd3: if (!m_tag[p]) begin e_fault = 1; m_c1 = 0; end
              else begin e_rv = 1; e_rd = m_reg[p]; m_c1 = 0; end
        3'd4: begin m_reg[p] = d; m_tag[p] = 1; m_c1 = 0; end
        3'd5: if (!m_tag[m_top]) begin e_fault = 1; m_c1 = 0; end
              else begin m_reg[p] = d; m_tag[p] = 1; m_tag[m_top] = 0;
                         m_top = m_top + 3'd1; m_c1 = 0; end
        default: ;
      endcase
    end
    op_valid = v; op_code = op; op_idx = idx; wr_data = d;
    @(negedge clk);
    op_valid = 1'b0;
    chk(req, "top_ptr", DW'(top_ptr), DW'(m_top));
    chk(req, "tag_full", DW'(tag_full), DW'(m_tag));
    chk(req, "stack_fault", DW'(stack_fault), DW'(e_fault));
    chk(req, "c1_flag", DW'(c1_flag), DW'(m_c1));
    chk(req, "rd_valid", DW'(rd_valid), DW'(e_rv));
    if (e_rv) chk(req, "rd_data", rd_data, e_rd);
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_top = '0; m_tag = '0; m_c1 = 1'b0;
    for (int k = 0; k < 8; k++) m_reg[k] = 'x;
    chk("R7", "top_ptr", DW'(top_ptr), '0);
    chk("R7", "tag_full", DW'(tag_full), '0);
    chk("R7", "stack_fault", DW'(stack_fault), '0);
    chk("R7", "c1_flag", DW'(c1_flag), '0);
    chk("R7", "rd_valid", DW'(rd_valid), '0);
  endtask

  task automatic t_push_pop();
    t_reset();
    do_op(1, 3'd1, 0, 80'h4000_8000_0000_0000_0000, "R2");
    chk("R2", "wrap top", DW'(top_ptr), DW'(3'd7));
    do_op(1, 3'd1, 0, 80'hC001_A5A5_5A5A_1234_5678, "R2");
    do_op(1, 3'd2, 0, '0, "R1");
    do_op(1, 3'd2, 0, '0, "R1");
    chk("R1", "top back at 0", DW'(top_ptr), '0);
  endtask

  task automatic t_overflow();
    t_reset();
    for (int k = 0; k < 8; k++)
      do_op(1, 3'd1, 0, DW'(80'h3FFF_0000_0000_0000_0000 + k * 80'h11), "R2");
    do_op(1, 3'd1, 0, 80'hDEAD_BEEF_DEAD_BEEF_DEAD, "R4");
    chk("R4", "c1 after overflow", DW'(c1_flag), DW'(1'b1));
    do_op(1, 3'd0, 0, '0, "R10");
    chk("R10", "c1 held on code 0", DW'(c1_flag), DW'(1'b1));
    do_op(1, 3'd6, 0, 80'h1, "R10");
    do_op(1, 3'd7, 2, 80'h2, "R10");
    do_op(0, 3'd1, 0, 80'h3, "R10");
    for (int k = 0; k < 8; k++) do_op(1, 3'd2, 0, '0, "R5");
  endtask

  task automatic t_underflow();
    t_reset();
    do_op(1, 3'd2, 0, '0, "R3");
    do_op(1, 3'd3, 3, '0, "R3");
    do_op(1, 3'd5, 1, 80'h7777, "R3");
    chk("R5", "tags untouched", DW'(tag_full), '0);
    do_op(1, 3'd1, 0, 80'h1234, "R2");
    do_op(1, 3'd3, 1, '0, "R3");
    do_op(1, 3'd3, 0, '0, "R5");
  endtask

  task automatic t_relative();
    t_reset();
    do_op(1, 3'd1, 0, 80'hAAAA, "R6");
    do_op(1, 3'd1, 0, 80'hBBBB, "R6");
    do_op(1, 3'd1, 0, 80'hCCCC, "R6");
    do_op(1, 3'd3, 0, '0, "R6");
    do_op(1, 3'd3, 1, '0, "R6");
    do_op(1, 3'd3, 2, '0, "R6");
    do_op(1, 3'd3, 5, '0, "R6");
    chk("R6", "phys 5..7 full", DW'(tag_full), DW'(8'hE0));
  endtask

  task automatic t_write();
    t_reset();
    do_op(1, 3'd4, 4, 80'h5555_6666, "R8");
    chk("R8", "tag of phys 4", DW'(tag_full[4]), DW'(1'b1));
    do_op(1, 3'd3, 4, '0, "R8");
    do_op(1, 3'd1, 0, 80'h9999, "R8");
    do_op(1, 3'd4, 0, 80'hABCD, "R8");
    do_op(1, 3'd3, 0, '0, "R8");
  endtask

  task automatic t_write_pop();
    t_reset();
    do_op(1, 3'd1, 0, 80'h1111, "R9");
    do_op(1, 3'd1, 0, 80'h2222, "R9");
    do_op(1, 3'd5, 1, 80'h3333, "R9");
    do_op(1, 3'd3, 0, '0, "R9");
    do_op(1, 3'd5, 0, 80'h4444, "R9");
    chk("R9", "stack empty", DW'(tag_full), '0);
    do_op(1, 3'd2, 0, '0, "R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_overflow();
    t_underflow();
    t_relative();
    t_write();
    t_write_pop();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule